// File: doc/BRIEF.md
# Dual-Port Block Memory with Selectable Write-Port Output Modes

This block is a synchronous true dual-port memory. Ports A and B share one clock. Each port has its own enable, write strobe, address, write data and registered read data. Either port can read or write any word in any cycle. A write made on one port can be read on the other port in any later cycle.

A parameter for each port chooses what that port's read register shows in a cycle where the port writes. There are three choices:

- **HOLD**: the register keeps its last value.
- **THRU**: the register takes the data being written.
- **OLD**: the register takes the word's contents from before the write.

OLD is allowed only for data widths of 9, 18 or 36 bits. Any other width with OLD stops elaboration with an error. Address width is derived from the depth, and the depth must be a power of two.

The read registers have two kinds of reset, both active low. A global reset clears both ports. A local reset for each port clears only that port. Both kinds assert asynchronously. Release passes through a two-stage synchronizer for each port. No reset ever touches the memory array. If both ports write the same word in the same cycle, the stored value is undefined. The same holds when one port reads a word that the other port writes in that cycle.

Top module: `dpram_wm`

## Requirements
- R1: With enable high and write low at a rising edge, the port's read data after that edge equals the word stored at the port's address. Read latency is one cycle.
- R2: On a port in HOLD mode, a write cycle (enable and write high) stores the data but leaves the port's read data unchanged.
- R3: On a port in THRU mode, a write cycle stores the data, and the port's read data after that edge equals the write data.
- R4: On a port in OLD mode, a write cycle stores the new data, and the port's read data after that edge equals the word's contents before the write.
- R5: With enable low, a port neither reads nor writes, whatever its write strobe and data, and its read data holds.
- R6: While the global reset `rst_n` is low, both read outputs are zero. The clear takes effect without waiting for a clock edge.
- R7: A local reset (`a_rst_n` or `b_rst_n`, active low) clears only its own port's read data, asynchronously. The other port's read data is not affected.
- R8: No reset, global or local, changes any stored word.
- R9: The ports are independent. Both ports may access different words in the same cycle, and a word written on one port is read back on the other port in a later cycle.
- R10: After a reset is released, a port accepts accesses again from the third rising edge on. Its read data stays zero until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Global reset, active low, for both read registers |
| a_rst_n | input | 1 | Port A local reset, active low |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write strobe |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_rst_n | input | 1 | Port B local reset, active low |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write strobe |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
The write-mode and idle properties assume that a port's enable stays low for the three edges that follow any reset release. During that window the synchronizer still holds the register at zero, so an access then would break the THRU property. The properties also take for granted that the two ports never touch the same word in one cycle while either of them writes. The random stimulus keeps to both limits. When two enabled addresses match and either port writes, it flips the low bit of port B's address. Every reset release is followed by three idle cycles.

// File: rtl/dpram_wm_pkg.sv
`timescale 1ns/1ps
package dpram_wm_pkg;

  // Output behaviour of a port during its own write cycle
  typedef enum logic [1:0] {
    WM_HOLD = 2'd0,  // read register keeps its value
    WM_THRU = 2'd1,  // read register takes the write data
    WM_OLD  = 2'd2   // read register takes the pre-write word
  } wmode_e;

  // Widths for which the pre-write read mode is permitted
  function automatic bit old_mode_width_ok(int unsigned w);
    return (w == 9) || (w == 18) || (w == 36);
  endfunction

endpackage

// File: rtl/dpram_wm_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, two-stage synchronous release
module dpram_wm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/dpram_wm_array.sv
`timescale 1ns/1ps
// Storage array: two write paths, two combinational read paths, no reset
module dpram_wm_array #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wdata_a,
  input  logic              wr_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wdata_b,
  output logic [DATA_W-1:0] word_a,
  output logic [DATA_W-1:0] word_b
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Pre-write contents feed the port output stages
  assign word_a = mem[addr_a];
  assign word_b = mem[addr_b];

  // Both writes in one process; a same-word collision is undefined
  always_ff @(posedge clk) begin
    if (wr_a) begin
      mem[addr_a] <= wdata_a;
    end
    if (wr_b) begin
      mem[addr_b] <= wdata_b;
    end
  end

endmodule

// File: rtl/dpram_wm_port.sv
`timescale 1ns/1ps
// One port's read register with its write-cycle output mode
module dpram_wm_port
  import dpram_wm_pkg::*;
#(
  parameter int     DATA_W = 18,
  parameter wmode_e MODE   = WM_HOLD
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              en,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] stored,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;
  logic              unused_inputs;

  if (MODE == WM_OLD && !old_mode_width_ok(DATA_W)) begin : g_bad_width
    $error("pre-write output mode needs a 9, 18 or 36 bit word");
  end

  if (MODE == WM_HOLD) begin : g_hold
    always_comb begin
      rdata_d = rdata_q;
      if (en && !we) begin
        rdata_d = stored;
      end
    end
    assign unused_inputs = ^wdata;
  end else if (MODE == WM_THRU) begin : g_thru
    always_comb begin
      rdata_d = rdata_q;
      if (en) begin
        rdata_d = we ? wdata : stored;
      end
    end
    assign unused_inputs = 1'b0;
  end else begin : g_old
    always_comb begin
      rdata_d = rdata_q;
      if (en) begin
        rdata_d = stored;
      end
    end
    assign unused_inputs = ^{we, wdata};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/dpram_wm.sv
`timescale 1ns/1ps
module dpram_wm
  import dpram_wm_pkg::*;
#(
  parameter int     DATA_W = 18,
  parameter int     DEPTH  = 256,
  parameter wmode_e MODE_A = WM_HOLD,
  parameter wmode_e MODE_B = WM_OLD,
  localparam int    ADDR_W = $clog2(DEPTH),
  localparam int    NPORT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_rst_n,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam wmode_e MODE_V [NPORT] = '{MODE_A, MODE_B};

  logic [NPORT-1:0]  lrst_v;
  logic [NPORT-1:0]  en_v;
  logic [NPORT-1:0]  we_v;
  logic [NPORT-1:0]  arst_v;
  logic [NPORT-1:0]  srst_v;
  logic [DATA_W-1:0] wd_v   [NPORT];
  logic [DATA_W-1:0] word_v [NPORT];
  logic [DATA_W-1:0] rd_v   [NPORT];

  assign lrst_v = {b_rst_n, a_rst_n};
  assign en_v   = {b_en, a_en};
  assign we_v   = {b_we, a_we};
  assign wd_v[0] = a_wdata;
  assign wd_v[1] = b_wdata;

  dpram_wm_array #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_array (
    .clk     (clk),
    .wr_a    (a_en & a_we),
    .addr_a  (a_addr),
    .wdata_a (a_wdata),
    .wr_b    (b_en & b_we),
    .addr_b  (b_addr),
    .wdata_b (b_wdata),
    .word_a  (word_v[0]),
    .word_b  (word_v[1])
  );

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
    // Global and local resets combine before the synchronizer
    assign arst_v[gi] = rst_n & lrst_v[gi];

    dpram_wm_rst_sync #(
      .STAGES (2)
    ) u_rsync (
      .clk    (clk),
      .arst_n (arst_v[gi]),
      .srst_n (srst_v[gi])
    );

    dpram_wm_port #(
      .DATA_W (DATA_W),
      .MODE   (MODE_V[gi])
    ) u_port (
      .clk    (clk),
      .srst_n (srst_v[gi]),
      .en     (en_v[gi]),
      .we     (we_v[gi]),
      .wdata  (wd_v[gi]),
      .stored (word_v[gi]),
      .rdata  (rd_v[gi])
    );
  end

  assign a_rdata = rd_v[0];
  assign b_rdata = rd_v[1];

endmodule

// File: rtl/dpram_wm_chk.sv
`timescale 1ns/1ps
module dpram_wm_chk
  import dpram_wm_pkg::*;
#(
  parameter int     DATA_W = 18,
  parameter wmode_e MODE_A = WM_HOLD,
  parameter wmode_e MODE_B = WM_OLD
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_rst_n,
  input logic              a_en,
  input logic              a_we,
  input logic [DATA_W-1:0] a_wdata,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_rst_n,
  input logic              b_en,
  input logic              b_we,
  input logic [DATA_W-1:0] b_wdata,
  input logic [DATA_W-1:0] b_rdata
);

  logic armed = 1'b0;
  logic unused_wd;

  assign unused_wd = ^{a_wdata, b_wdata};

  always_ff @(posedge clk) begin
    armed <= 1'b1;
  end

  // R6: global reset holds both outputs at zero
  a_r6_global_clear: assert property (@(posedge clk)
    armed && !rst_n |-> (a_rdata == '0) && (b_rdata == '0));

  // R7: a local reset holds its own output at zero
  a_r7_local_clear_a: assert property (@(posedge clk)
    armed && !a_rst_n |-> a_rdata == '0);
  a_r7_local_clear_b: assert property (@(posedge clk)
    armed && !b_rst_n |-> b_rdata == '0);

  // R5: an idle port keeps its output
  a_r5_idle_hold_a: assert property (@(posedge clk) disable iff (!rst_n || !a_rst_n)
    !a_en |=> $stable(a_rdata));
  a_r5_idle_hold_b: assert property (@(posedge clk) disable iff (!rst_n || !b_rst_n)
    !b_en |=> $stable(b_rdata));

  if (MODE_A == WM_HOLD) begin : g_a_hold
    a_r2_write_holds_a: assert property (@(posedge clk) disable iff (!rst_n || !a_rst_n)
      a_en && a_we |=> $stable(a_rdata));
  end else if (MODE_A == WM_THRU) begin : g_a_thru
    a_r3_write_thru_a: assert property (@(posedge clk) disable iff (!rst_n || !a_rst_n)
      a_en && a_we |=> a_rdata == $past(a_wdata));
  end

  if (MODE_B == WM_HOLD) begin : g_b_hold
    a_r2_write_holds_b: assert property (@(posedge clk) disable iff (!rst_n || !b_rst_n)
      b_en && b_we |=> $stable(b_rdata));
  end else if (MODE_B == WM_THRU) begin : g_b_thru
    a_r3_write_thru_b: assert property (@(posedge clk) disable iff (!rst_n || !b_rst_n)
      b_en && b_we |=> b_rdata == $past(b_wdata));
  end

endmodule

bind dpram_wm dpram_wm_chk #(
  .DATA_W (DATA_W),
  .MODE_A (MODE_A),
  .MODE_B (MODE_B)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_rst_n (a_rst_n),
  .a_en    (a_en),
  .a_we    (a_we),
  .a_wdata (a_wdata),
  .a_rdata (a_rdata),
  .b_rst_n (b_rst_n),
  .b_en    (b_en),
  .b_we    (b_we),
  .b_wdata (b_wdata),
  .b_rdata (b_rdata)
);

// File: tb/dpram_wm_tb_top.sv
`timescale 1ns/1ps
module dpram_wm_tb_top;
  import dpram_wm_pkg::*;

  localparam int W  = 18;
  localparam int D  = 256;
  localparam int AW = $clog2(D);
  // dut_i: A=HOLD, B=OLD ; dut2_i: A=THRU, B=HOLD
  localparam wmode_e M1A = WM_HOLD;
  localparam wmode_e M1B = WM_OLD;
  localparam wmode_e M2A = WM_THRU;
  localparam wmode_e M2B = WM_HOLD;

  logic          clk = 1'b0;
  logic          rst_n, a_rst_n, b_rst_n;
  logic          ae, awe, be, bwe;
  logic [AW-1:0] aa, ba;
  logic [W-1:0]  ad, bd;
  logic [W-1:0]  ra1, rb1, ra2, rb2;
  logic [W-1:0]  ea1, eb1, ea2, eb2;
  logic [W-1:0]  model [D];
  int            errors = 0;
  int            checks = 0;

  always #4 clk = ~clk;

  dpram_wm #(.DATA_W(W), .DEPTH(D), .MODE_A(M1A), .MODE_B(M1B)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_rst_n(a_rst_n), .a_en(ae), .a_we(awe), .a_addr(aa), .a_wdata(ad), .a_rdata(ra1),
    .b_rst_n(b_rst_n), .b_en(be), .b_we(bwe), .b_addr(ba), .b_wdata(bd), .b_rdata(rb1));

  dpram_wm #(.DATA_W(W), .DEPTH(D), .MODE_A(M2A), .MODE_B(M2B)) dut2_i (
    .clk(clk), .rst_n(rst_n),
    .a_rst_n(a_rst_n), .a_en(ae), .a_we(awe), .a_addr(aa), .a_wdata(ad), .a_rdata(ra2),
    .b_rst_n(b_rst_n), .b_en(be), .b_we(bwe), .b_addr(ba), .b_wdata(bd), .b_rdata(rb2));

  function automatic logic [W-1:0] predict(wmode_e m, logic en, logic we,
                                           logic [W-1:0] wd, logic [W-1:0] old,
                                           logic [W-1:0] prev);
    if (!en) return prev;
    case (m)
      WM_HOLD: return we ? prev : old;
      WM_THRU: return we ? wd : old;
      default: return old;
    endcase
  endfunction

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, "dut_i A", ra1, ea1);
    check(req, "dut_i B", rb1, eb1);
    check(req, "dut2_i A", ra2, ea2);
    check(req, "dut2_i B", rb2, eb2);
  endtask

  task automatic drive(logic e0, logic w0, int a0, logic [W-1:0] d0,
                       logic e1, logic w1, int a1, logic [W-1:0] d1);
    ae = e0; awe = w0; aa = AW'(a0); ad = d0;
    be = e1; bwe = w1; ba = AW'(a1); bd = d1;
  endtask

  // Called just after a falling edge with inputs set
  task automatic step(string req);
    logic [W-1:0] oa, ob;
    oa  = model[aa];
    ob  = model[ba];
    ea1 = predict(M1A, ae, awe, ad, oa, ea1);
    eb1 = predict(M1B, be, bwe, bd, ob, eb1);
    ea2 = predict(M2A, ae, awe, ad, oa, ea2);
    eb2 = predict(M2B, be, bwe, bd, ob, eb2);
    @(posedge clk);
    if (ae && awe) model[aa] = ad;
    if (be && bwe) model[ba] = bd;
    #2;
    check_all(req);
    @(negedge clk);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 0, '0, 0, 0, 0, '0);
      step(req);
    end
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h1d5a);
    rst_n = 1'b0; a_rst_n = 1'b1; b_rst_n = 1'b1;
    drive(0, 0, 0, '0, 0, 0, 0, '0);
    ea1 = '0; eb1 = '0; ea2 = '0; eb2 = '0;
    for (int i = 0; i < D; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check_all("R6 reset state");
    rst_n = 1'b1;
    idle(3, "R10");

    // Fill: port A writes, port B reads the word written two steps back (R9)
    for (int i = 0; i < D; i++) begin
      drive(1, 1, i, W'(i * 37 + 5), (i >= 2), 0, i - 2, '0);
      step("R2 R3 R9");
    end

    drive(1, 0, 10, '0, 1, 0, 20, '0);
    step("R1");
    drive(1, 0, 11, W'(18'h3ffff), 1, 1, 30, W'(18'h2aaaa));
    step("R4");
    drive(0, 0, 0, '0, 1, 0, 30, '0);
    step("R4 readback");
    drive(1, 1, 40, W'(18'h15555), 0, 0, 0, '0);
    step("R3");
    drive(1, 1, 41, W'(18'h00f0f), 0, 0, 0, '0);
    step("R2");
    drive(0, 1, 50, W'(18'h12345), 0, 1, 51, W'(18'h0abcd));
    step("R5 idle write");
    drive(1, 0, 50, '0, 1, 0, 51, '0);
    step("R5 no store");
    drive(1, 1, 60, W'(18'h0c0de), 1, 1, 61, W'(18'h1beef));
    step("R9 dual write");
    drive(1, 0, 61, '0, 1, 0, 60, '0);
    step("R9 cross read");

    // Global reset mid-run, asynchronous
    #1 rst_n = 1'b0;
    #1;
    ea1 = '0; eb1 = '0; ea2 = '0; eb2 = '0;
    check_all("R6 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    drive(1, 0, 10, '0, 1, 0, 30, '0);
    ea1 = '0; eb1 = '0; ea2 = '0; eb2 = '0;
    @(posedge clk); #2; check_all("R10 held");
    @(negedge clk);
    @(posedge clk); #2; check_all("R10 held");
    @(negedge clk);
    step("R8 R10 after global");

    // Local reset on port A only
    #1 a_rst_n = 1'b0;
    #1;
    ea1 = '0; ea2 = '0;
    check_all("R7 local A");
    @(negedge clk);
    a_rst_n = 1'b1;
    idle(3, "R7 R10");
    drive(1, 0, 61, '0, 1, 0, 41, '0);
    step("R8 after local A");

    // Local reset on port B only
    #1 b_rst_n = 1'b0;
    #1;
    eb1 = '0; eb2 = '0;
    check_all("R7 local B");
    @(negedge clk);
    b_rst_n = 1'b1;
    idle(3, "R7 R10");
    drive(1, 0, 40, '0, 1, 0, 60, '0);
    step("R8 after local B");

    // Constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic e0, w0, e1, w1;
      int a0, a1;
      e0 = ($urandom_range(0, 3) != 0);
      w0 = $urandom_range(0, 1) == 1;
      e1 = ($urandom_range(0, 3) != 0);
      w1 = $urandom_range(0, 1) == 1;
      a0 = $urandom_range(0, 31);
      a1 = $urandom_range(0, 31);
      if (e0 && e1 && (a0 == a1) && (w0 || w1)) a1 = a1 ^ 1;
      drive(e0, w0, a0, W'($urandom()), e1, w1, a1, W'($urandom()));
      step("R1 R2 R3 R4 R5 R9 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule